// File: doc/BRIEF.md
# Placeholder Level-2 Cache Controller Register Block

This block occupies the register window of a level-2 cache controller on a system where no real cache sits behind it. Software that probes, configures and maintains the cache finds registers that behave sensibly. It can read an identity word and a cache-type word. It can program control, auxiliary, latency and address-filter registers and read them back. Every maintenance operation it starts is reported as already finished. The block contains no cache storage, no tags and no flush engine.

Access is through a 32-bit APB-style slave port. Only the low 12 bits of the address are decoded, so the 4 KB map repeats across the wider address space. Every access finishes in its access cycle. During that cycle an error strobe marks any access that falls outside the map, and any write to one of the two read-only identification words.

Top module: `l2stub_regs`

## Requirements
- R1: After reset, reads return 0x02020000 from the auxiliary register (offset 0x104) and zero from control (0x100), tag latency (0x108), data latency (0x10C), filter start (0xC00) and filter end (0xC04).
- R2: A read of offset 0x000 returns the identity value (default 0x410000C8) with no error. A write to 0x000 changes nothing and raises the error strobe.
- R3: A write to control (0x100) keeps only bit 0. Bits 31:1 of control always read as zero.
- R4: Auxiliary, tag latency, data latency, filter start and filter end store all 32 written bits and return them on read.
- R5: A read of 0x004 builds a 5-bit code. Code bits 4:2 are auxiliary bits 19:17, code bit 1 is zero, and code bit 0 is auxiliary bit 16. The read returns the stored cache-type word ORed with the code shifted left by 18 and with the code shifted left by 6.
- R6: The value returned by a 0x004 read is also written back, so bits set by earlier reads stay set after the auxiliary register changes. A write to 0x004 changes nothing and raises the error strobe.
- R7: Offsets 0x730 through 0x7FF read as zero, drop writes and raise no error. Offsets 0x72C and 0x800 are outside this range.
- R8: Offsets 0xF40, 0xF60 and 0xF80 read as zero, drop writes and raise no error.
- R9: Any other offset reads as zero and drops writes. The error strobe is high in that access cycle only.
- R10: Address bits above bit 11 are ignored, so an offset reached through any 4 KB alias behaves the same.
- R11: Ready is high in exactly the cycles where select and enable are both high, and low in the setup cycle.
- R12: Reset reloads the cache-type word with its parameter default (0x1C100100), which clears any bits accumulated by earlier reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase enable |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address; only bits 11:0 are decoded |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while ready is high |
| pready | output | 1 | Access completes in this cycle |
| bad_access | output | 1 | Error strobe for unmapped offsets and read-only writes |

## Verification
The bench builds the block with its default parameters: a 32-bit address, the standard identity and cache-type defaults, and the accumulating cache-type variant. The wide address lets it drive accesses through aliases far above the 4 KB window. The auxiliary reset value and the default cache-type word overlap in their code bits, so the first readback shows no visible change. Programming the auxiliary bits 19:16 then exposes both shifted copies of the code. Clearing them again shows that those bits stick, and a mid-run reset shows they are cleared.

// File: rtl/l2stub_pkg.sv
package l2stub_pkg;

   localparam int unsigned WORD_W = 32;
   localparam int unsigned OFS_W  = 12;

   typedef enum logic [3:0] {
      K_IDENT,
      K_CTYPE,
      K_CTRL,
      K_AUX,
      K_TAGLAT,
      K_DATLAT,
      K_FLO,
      K_FHI,
      K_MAINT,
      K_QUIET,
      K_BAD
   } reg_kind_e;

   localparam logic [OFS_W-1:0] OFS_IDENT  = 12'h000;
   localparam logic [OFS_W-1:0] OFS_CTYPE  = 12'h004;
   localparam logic [OFS_W-1:0] OFS_CTRL   = 12'h100;
   localparam logic [OFS_W-1:0] OFS_AUX    = 12'h104;
   localparam logic [OFS_W-1:0] OFS_TAGLAT = 12'h108;
   localparam logic [OFS_W-1:0] OFS_DATLAT = 12'h10C;
   localparam logic [OFS_W-1:0] OFS_FLO    = 12'hC00;
   localparam logic [OFS_W-1:0] OFS_FHI    = 12'hC04;
   localparam logic [OFS_W-1:0] OFS_Q0     = 12'hF40;
   localparam logic [OFS_W-1:0] OFS_Q1     = 12'hF60;
   localparam logic [OFS_W-1:0] OFS_Q2     = 12'hF80;

endpackage

// File: rtl/l2stub_decode.sv
module l2stub_decode
   import l2stub_pkg::*;
#(
   parameter int unsigned MAINT_LO = 12'h730,
   parameter int unsigned MAINT_HI = 12'h800
) (
   input  logic [OFS_W-1:0] ofs,
   output reg_kind_e        kind
);

   localparam logic [OFS_W:0] LO_X = (OFS_W+1)'(MAINT_LO);
   localparam logic [OFS_W:0] HI_X = (OFS_W+1)'(MAINT_HI);

   initial begin
      if (MAINT_LO >= MAINT_HI) $error("maintenance range is empty");
      if (MAINT_HI > (1 << OFS_W)) $error("maintenance range exceeds window");
   end

   logic [OFS_W:0] ofs_x;
   logic           in_maint;

   always_comb begin
      ofs_x    = {1'b0, ofs};
      in_maint = (ofs_x >= LO_X) && (ofs_x < HI_X);
      if (in_maint) begin
         kind = K_MAINT;
      end else begin
         unique case (ofs)
            OFS_IDENT:               kind = K_IDENT;
            OFS_CTYPE:               kind = K_CTYPE;
            OFS_CTRL:                kind = K_CTRL;
            OFS_AUX:                 kind = K_AUX;
            OFS_TAGLAT:              kind = K_TAGLAT;
            OFS_DATLAT:              kind = K_DATLAT;
            OFS_FLO:                 kind = K_FLO;
            OFS_FHI:                 kind = K_FHI;
            OFS_Q0, OFS_Q1, OFS_Q2:  kind = K_QUIET;
            default:                 kind = K_BAD;
         endcase
      end
   end

endmodule

// File: rtl/l2stub_cfg_regs.sv
module l2stub_cfg_regs
   import l2stub_pkg::*;
#(
   parameter logic [WORD_W-1:0] AUX_RESET = 32'h0202_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  reg_kind_e         kind,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata,
   output logic [WORD_W-1:0] aux_q
);

   logic              ctrl_q;
   logic [WORD_W-1:0] tag_q, dat_q, flo_q, fhi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= 1'b0;
         aux_q  <= AUX_RESET;
         tag_q  <= '0;
         dat_q  <= '0;
         flo_q  <= '0;
         fhi_q  <= '0;
      end else if (wr_en) begin
         case (kind)
            K_CTRL:   ctrl_q <= wdata[0];
            K_AUX:    aux_q  <= wdata;
            K_TAGLAT: tag_q  <= wdata;
            K_DATLAT: dat_q  <= wdata;
            K_FLO:    flo_q  <= wdata;
            K_FHI:    fhi_q  <= wdata;
            default:  ;
         endcase
      end
   end

   always_comb begin
      case (kind)
         K_CTRL:   rdata = {{(WORD_W-1){1'b0}}, ctrl_q};
         K_AUX:    rdata = aux_q;
         K_TAGLAT: rdata = tag_q;
         K_DATLAT: rdata = dat_q;
         K_FLO:    rdata = flo_q;
         K_FHI:    rdata = fhi_q;
         default:  rdata = '0;
      endcase
   end

   p_skip_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (kind == K_MAINT || kind == K_QUIET || kind == K_BAD))
      |=> ($stable(aux_q) && $stable(tag_q) && $stable(dat_q) &&
           $stable(flo_q) && $stable(fhi_q) && $stable(ctrl_q)));

endmodule

// File: rtl/l2stub_ctype.sv
module l2stub_ctype
   import l2stub_pkg::*;
#(
   parameter logic [WORD_W-1:0] TYPE_DEFAULT = 32'h1C10_0100,
   parameter bit                STICKY       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [3:0]        aux_sel,
   output logic [WORD_W-1:0] rdata
);

   localparam int unsigned HI_SHIFT = 18;
   localparam int unsigned LO_SHIFT = 6;

   logic [4:0]        code;
   logic [WORD_W-1:0] spread;
   logic [WORD_W-1:0] type_q;

   always_comb begin
      code   = {aux_sel[3:1], 1'b0, aux_sel[0]};
      spread = (WORD_W'(code) << HI_SHIFT) | (WORD_W'(code) << LO_SHIFT);
      rdata  = type_q | spread;
   end

   generate
      if (STICKY) begin : g_accumulate
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     type_q <= TYPE_DEFAULT;
            else if (rd_en) type_q <= rdata;
         end

         p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en |=> ((type_q & $past(rdata)) == $past(rdata)));
      end else begin : g_fixed
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) type_q <= TYPE_DEFAULT;
         end
         logic unused_rd;
         assign unused_rd = rd_en;
      end
   endgenerate

   p_keep_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((type_q & $past(type_q)) == $past(type_q)));

endmodule

// File: rtl/l2stub_regs.sv
module l2stub_regs
   import l2stub_pkg::*;
#(
   parameter int unsigned       ADDR_W       = 32,
   parameter logic [WORD_W-1:0] IDENT_VALUE  = 32'h4100_00C8,
   parameter logic [WORD_W-1:0] TYPE_DEFAULT = 32'h1C10_0100,
   parameter logic [WORD_W-1:0] AUX_RESET    = 32'h0202_0000,
   parameter int unsigned       MAINT_LO     = 12'h730,
   parameter int unsigned       MAINT_HI     = 12'h800,
   parameter bit                TYPE_STICKY  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   output logic              pready,
   output logic              bad_access
);

   initial begin
      if (ADDR_W < OFS_W) $error("address must cover the 4 KB window");
   end

   logic [OFS_W-1:0]  ofs;
   reg_kind_e         kind;
   logic              access;
   logic              ro_write;
   logic [WORD_W-1:0] cfg_rdata, type_rdata, aux_q;

   assign ofs = paddr[OFS_W-1:0];

   generate
      if (ADDR_W > OFS_W) begin : g_alias
         logic unused_hi;
         assign unused_hi = ^paddr[ADDR_W-1:OFS_W];
      end
   endgenerate

   l2stub_decode #(.MAINT_LO(MAINT_LO), .MAINT_HI(MAINT_HI)) u_dec (
      .ofs  (ofs),
      .kind (kind)
   );

   assign access   = psel && penable;
   assign ro_write = pwrite && (kind == K_IDENT || kind == K_CTYPE);

   l2stub_cfg_regs #(.AUX_RESET(AUX_RESET)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (access && pwrite),
      .kind  (kind),
      .wdata (pwdata),
      .rdata (cfg_rdata),
      .aux_q (aux_q)
   );

   l2stub_ctype #(.TYPE_DEFAULT(TYPE_DEFAULT), .STICKY(TYPE_STICKY)) u_type (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (access && !pwrite && kind == K_CTYPE),
      .aux_sel (aux_q[19:16]),
      .rdata   (type_rdata)
   );

   logic unused_aux;
   assign unused_aux = ^{aux_q[31:20], aux_q[15:0]};

   always_comb begin
      prdata = '0;
      if (access && !pwrite) begin
         case (kind)
            K_IDENT: prdata = IDENT_VALUE;
            K_CTYPE: prdata = type_rdata;
            default: prdata = cfg_rdata;
         endcase
      end
   end

   assign pready     = access;
   assign bad_access = access && (kind == K_BAD || ro_write);

   p_err_in_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bad_access |-> pready);

   p_bad_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_access && !pwrite) |-> (prdata == '0));

   p_maint_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (access && (kind == K_MAINT || kind == K_QUIET)) |-> (!bad_access && prdata == '0));

   p_ident_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (access && !pwrite && kind == K_IDENT) |-> (prdata == IDENT_VALUE));

   p_no_ready_setup_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && !penable) |-> !pready);

endmodule

// File: tb/tb_l2stub_regs.sv
module tb_l2stub_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [31:0] paddr = '0, pwdata = '0;
   logic [31:0] prdata;
   logic        pready, bad_access;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   l2stub_regs dut (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
      .prdata(prdata), .pready(pready), .bad_access(bad_access)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic wr, input logic [31:0] a, input logic [31:0] d,
                       input logic exp_err, input string req, output logic [31:0] rd);
      @(negedge clk);
      psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
      #1 chk({req, "/R11 setup ready"}, {31'b0, pready}, 32'd0);
      @(negedge clk);
      penable = 1'b1;
      #1;
      chk({req, "/R11 access ready"}, {31'b0, pready}, 32'd1);
      chk({req, " err"}, {31'b0, bad_access}, {31'b0, exp_err});
      rd = prdata;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
      #1 chk({req, "/R9 err one cycle"}, {31'b0, bad_access}, 32'd0);
   endtask

   task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic exp_err, input string req);
      logic [31:0] rd;
      xfer(1'b1, a, d, exp_err, req, rd);
   endtask

   task automatic rd_chk(input logic [31:0] a, input logic [31:0] exp, input logic exp_err, input string req);
      logic [31:0] rd;
      xfer(1'b0, a, 32'h0, exp_err, req, rd);
      chk(req, rd, exp);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_reset_values();
      rd_chk(32'h104, 32'h0202_0000, 1'b0, "R1 aux");
      rd_chk(32'h100, 32'h0, 1'b0, "R1 ctrl");
      rd_chk(32'h108, 32'h0, 1'b0, "R1 tag");
      rd_chk(32'h10C, 32'h0, 1'b0, "R1 data");
      rd_chk(32'hC00, 32'h0, 1'b0, "R1 flo");
      rd_chk(32'hC04, 32'h0, 1'b0, "R1 fhi");
   endtask

   task automatic t_ident();
      rd_chk(32'h000, 32'h4100_00C8, 1'b0, "R2 ident");
      wr(32'h000, 32'hFFFF_FFFF, 1'b1, "R2 ident write");
      rd_chk(32'h000, 32'h4100_00C8, 1'b0, "R2 ident after write");
   endtask

   task automatic t_ctrl();
      wr(32'h100, 32'hFFFF_FFFF, 1'b0, "R3 ctrl wr");
      rd_chk(32'h100, 32'h1, 1'b0, "R3 ctrl bit0");
      wr(32'h100, 32'hFFFF_FFFE, 1'b0, "R3 ctrl wr2");
      rd_chk(32'h100, 32'h0, 1'b0, "R3 ctrl cleared");
   endtask

   task automatic t_full();
      wr(32'h108, 32'hDEAD_BEEF, 1'b0, "R4 tag");
      wr(32'h10C, 32'h1234_5678, 1'b0, "R4 data");
      wr(32'hC00, 32'h8000_0001, 1'b0, "R4 flo");
      wr(32'hC04, 32'hFFFF_F000, 1'b0, "R4 fhi");
      rd_chk(32'h108, 32'hDEAD_BEEF, 1'b0, "R4 tag rb");
      rd_chk(32'h10C, 32'h1234_5678, 1'b0, "R4 data rb");
      rd_chk(32'hC00, 32'h8000_0001, 1'b0, "R4 flo rb");
      rd_chk(32'hC04, 32'hFFFF_F000, 1'b0, "R4 fhi rb");
   endtask

   task automatic t_ctype();
      rd_chk(32'h004, 32'h1C10_0100, 1'b0, "R5 type from reset aux");
      wr(32'h104, 32'h000F_0000, 1'b0, "R5 aux set");
      rd_chk(32'h004, 32'h1C74_0740, 1'b0, "R5 type with code 1D");
      wr(32'h104, 32'h0, 1'b0, "R6 aux clear");
      rd_chk(32'h004, 32'h1C74_0740, 1'b0, "R6 type sticky");
      wr(32'h004, 32'h0, 1'b1, "R6 type write");
      rd_chk(32'h004, 32'h1C74_0740, 1'b0, "R6 type unchanged");
      rd_chk(32'h104, 32'h0, 1'b0, "R4 aux rb");
   endtask

   task automatic t_maint();
      wr(32'h104, 32'hCAFE_0000, 1'b0, "R7 aux prep");
      wr(32'h730, 32'hFFFF_FFFF, 1'b0, "R7 maint lo write");
      wr(32'h7FC, 32'hFFFF_FFFF, 1'b0, "R7 maint hi write");
      rd_chk(32'h730, 32'h0, 1'b0, "R7 maint lo");
      rd_chk(32'h77C, 32'h0, 1'b0, "R7 maint mid");
      rd_chk(32'h7FC, 32'h0, 1'b0, "R7 maint top");
      rd_chk(32'h72C, 32'h0, 1'b1, "R7 below range");
      rd_chk(32'h800, 32'h0, 1'b1, "R7 above range");
      rd_chk(32'h104, 32'hCAFE_0000, 1'b0, "R7 aux intact");
   endtask

   task automatic t_quiet();
      wr(32'hF40, 32'h1, 1'b0, "R8 F40 wr");
      wr(32'hF60, 32'h1, 1'b0, "R8 F60 wr");
      wr(32'hF80, 32'h1, 1'b0, "R8 F80 wr");
      rd_chk(32'hF40, 32'h0, 1'b0, "R8 F40");
      rd_chk(32'hF60, 32'h0, 1'b0, "R8 F60");
      rd_chk(32'hF80, 32'h0, 1'b0, "R8 F80");
   endtask

   task automatic t_bad();
      wr(32'h200, 32'h1234_5678, 1'b1, "R9 bad write");
      rd_chk(32'h200, 32'h0, 1'b1, "R9 bad read");
      wr(32'hFFC, 32'hFFFF_FFFF, 1'b1, "R9 bad write top");
      rd_chk(32'h108, 32'hDEAD_BEEF, 1'b0, "R9 tag intact");
      rd_chk(32'hC04, 32'hFFFF_F000, 1'b0, "R9 fhi intact");
   endtask

   task automatic t_alias();
      wr(32'h5000_0108, 32'h0000_A5A5, 1'b0, "R10 alias write");
      rd_chk(32'h108, 32'h0000_A5A5, 1'b0, "R10 alias rb");
      rd_chk(32'hFFFF_F000, 32'h4100_00C8, 1'b0, "R10 alias ident");
      rd_chk(32'h8000_0F40, 32'h0, 1'b0, "R10 alias quiet");
   endtask

   task automatic t_reset_reload();
      do_reset();
      rd_chk(32'h004, 32'h1C10_0100, 1'b0, "R12 type reloaded");
      rd_chk(32'h104, 32'h0202_0000, 1'b0, "R12 aux reloaded");
      rd_chk(32'h108, 32'h0, 1'b0, "R12 tag cleared");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1 chk("R11 idle ready", {31'b0, pready}, 32'd0);
      t_reset_values();
      t_ident();
      t_ctrl();
      t_full();
      t_ctype();
      t_maint();
      t_quiet();
      t_bad();
      t_alias();
      t_reset_reload();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule